// File: doc/BRIEF.md
# Push-Pull Phase Generator with Sync Clock

This block turns a free-running oscillator tick into the two gate-drive enables of a push-pull power stage and into a synchronizing clock for a PWM controller further down the power path. The oscillator arrives as a one-cycle pulse, `osc_tick`, in the system clock domain. The oscillator square wave is taken to change level on every tick, so fOSC is half the tick rate. One divider counts ticks. A toggle stage turns its taps into two complementary, 50% duty drive phases and into the sync clock. A two-bit select sets the sync-to-drive frequency ratio to 1, 2 or 4, or switches every output off.

A supply-good input acts as an undervoltage lockout. While it is low, all three outputs are held low. Every output is a register, so no decode glitch can reach a pin. A control state machine has four states. `ST_LOCK` is the lockout state and the reset state. `ST_OFF` is entered on select code 00. `ST_ARM` has the outputs low and waits for the first tick. `ST_RUN` is normal operation. The transitions are:
- lockout: any state goes to `ST_LOCK` when `supply_ok` is low.
- disable: any state goes to `ST_OFF` when the select code is 00.
- wake: `ST_LOCK` or `ST_OFF` goes to `ST_ARM` once the supply is good and the code is not 00.
- start: `ST_ARM` goes to `ST_RUN` on a tick.
- restart: `ST_ARM` or `ST_RUN` goes to `ST_ARM` when the select code changes to another code that is not 00.

Top module: `pp_phase_gen`

## Requirements
- R1: While running, `drive_a` and `drive_b` are complementary. The two are never high in the same cycle.
- R2: With `ratio_sel` = 2'b00, all three outputs are low from the cycle after the code is applied, whatever the ticks do.
- R3: With `ratio_sel` = 2'b01 (ratio 1), the drive phases and `sync_clk` all change level every second tick. `sync_clk` follows the same waveform as `drive_a`.
- R4: With `ratio_sel` = 2'b10 (ratio 2), `sync_clk` changes level on every tick. The drive phases change level every second tick.
- R5: With `ratio_sel` = 2'b11 (ratio 4), `sync_clk` changes level on every tick. The drive phases change level every fourth tick.
- R6: Every drive edge during running lands in the same cycle as a `sync_clk` edge. A drive edge never leads the sync clock.
- R7: While `supply_ok` is low, all outputs are low from the next cycle, even when ticks arrive. After `supply_ok` returns high, the block waits in the armed state with the outputs low and restarts on the next tick.
- R8: A change of `ratio_sel` forces all outputs low in the next cycle. This holds even when a tick arrives in the same cycle. The first tick after that sets `drive_a` = 1, `drive_b` = 0 and `sync_clk` = 1.
- R9: After a start, the first `drive_a` pulse lasts a full half period. That is 2 ticks at ratio 1 or 2, and 4 ticks at ratio 4.
- R10: Outputs change only in the clock cycle after a sampled tick. The exceptions are the forced-low cases of R2, R7 and R8.
- R11: During reset and right after it, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator half period |
| supply_ok | input | 1 | Supply good; low forces lockout |
| ratio_sel | input | 2 | Select: 00 off, 01 ratio 1, 10 ratio 2, 11 ratio 4 |
| drive_a | output | 1 | Drive phase 1 (true output of the toggle) |
| drive_b | output | 1 | Drive phase 2 (inverted output of the toggle) |
| sync_clk | output | 1 | Synchronizing clock for the PWM controller |

## Verification
Two events can land on the same clock edge. The first case is a tick that arrives with a select change. The bench raises `osc_tick` and changes `ratio_sel` in the same cycle and expects all outputs low, not a phase step. The second case is a tick that arrives as `supply_ok` falls, where lockout must win and the outputs must read low one cycle later. In both cases the bench then checks that the next lone tick restarts with `drive_a` high and `sync_clk` high.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_X1  = 2'b01,
        MODE_X2  = 2'b10,
        MODE_X4  = 2'b11
    } ratio_mode_t;

    typedef enum logic [1:0] {
        ST_LOCK = 2'b00,
        ST_OFF  = 2'b01,
        ST_ARM  = 2'b10,
        ST_RUN  = 2'b11
    } pp_state_t;

endpackage

// File: rtl/pp_sel_decode.sv
module pp_sel_decode
    import pp_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    output ratio_mode_t      mode,
    output logic             sel_changed
);

    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= ratio_sel;
        end
    end

    always_comb begin
        unique case (ratio_sel[1:0])
            2'b00:   mode = MODE_OFF;
            2'b01:   mode = MODE_X1;
            2'b10:   mode = MODE_X2;
            default: mode = MODE_X4;
        endcase
        sel_changed = (ratio_sel != sel_q);
    end

endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
    import pp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        supply_ok,
    input  logic        osc_tick,
    input  ratio_mode_t mode,
    input  logic        sel_changed,
    output pp_state_t   state_q,
    output logic        step,
    output logic        first,
    output logic        clear
);

    pp_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCK;
        end else begin
            state_q <= nxt;
        end
    end

    always_comb begin
        nxt = state_q;
        if (!supply_ok) begin
            nxt = ST_LOCK;
        end else if (mode == MODE_OFF) begin
            nxt = ST_OFF;
        end else begin
            unique case (state_q)
                ST_LOCK: nxt = ST_ARM;
                ST_OFF:  nxt = ST_ARM;
                ST_ARM:  nxt = sel_changed ? ST_ARM : (osc_tick ? ST_RUN : ST_ARM);
                ST_RUN:  nxt = sel_changed ? ST_ARM : ST_RUN;
            endcase
        end
    end

    always_comb begin
        step  = (nxt == ST_RUN) && osc_tick;
        first = (state_q == ST_ARM);
        clear = (nxt != ST_RUN);
    end

    // Lockout always overrides the select path.
    assert_lock_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_q == ST_LOCK));

    // A select change never lets the machine run on.
    assert_restart_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_changed && supply_ok && mode != MODE_OFF) |=> (state_q == ST_ARM));

endmodule

// File: rtl/pp_tick_div.sv
module pp_tick_div
    import pp_pkg::*;
#(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        step,
    input  logic        first,
    input  ratio_mode_t mode,
    output logic        sync_tgl,
    output logic        drv_tgl
);

    localparam int CNT_W = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
    localparam logic [CNT_W-1:0] FAST_MASK = CNT_W'(FAST_HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] k;
    logic             fast_hit;
    logic             slow_hit;

    always_comb begin
        k        = first ? '0 : cnt_q;
        fast_hit = ((k & FAST_MASK) == '0);
        slow_hit = (k == '0);
    end

    always_comb begin
        unique case (mode)
            MODE_OFF: begin sync_tgl = 1'b0;     drv_tgl = 1'b0;     end
            MODE_X1:  begin sync_tgl = fast_hit; drv_tgl = fast_hit; end
            MODE_X2:  begin sync_tgl = 1'b1;     drv_tgl = fast_hit; end
            MODE_X4:  begin sync_tgl = 1'b1;     drv_tgl = slow_hit; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= k + 1'b1;
        end
    end

    // The start tick is always a phase boundary.
    assert_first_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && first) |-> (drv_tgl && sync_tgl));

endmodule

// File: rtl/pp_out_stage.sv
module pp_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic first,
    input  logic sync_tgl,
    input  logic drv_tgl,
    output logic drive_a,
    output logic drive_b,
    output logic sync_clk
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drive_a  <= 1'b0;
            drive_b  <= 1'b0;
            sync_clk <= 1'b0;
        end else if (clear) begin
            drive_a  <= 1'b0;
            drive_b  <= 1'b0;
            sync_clk <= 1'b0;
        end else if (step) begin
            if (first) begin
                drive_a  <= 1'b1;
                drive_b  <= 1'b0;
                sync_clk <= 1'b1;
            end else begin
                drive_a  <= drive_a ^ drv_tgl;
                drive_b  <= drive_b ^ drv_tgl;
                sync_clk <= sync_clk ^ sync_tgl;
            end
        end
    end

    assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(drive_a && drive_b));

endmodule

// File: rtl/pp_phase_gen.sv
module pp_phase_gen
    import pp_pkg::*;
#(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       supply_ok,
    input  logic [1:0] ratio_sel,
    output logic       drive_a,
    output logic       drive_b,
    output logic       sync_clk
);

    ratio_mode_t mode;
    pp_state_t   state_q;
    logic        sel_changed;
    logic        step;
    logic        first;
    logic        clear;
    logic        sync_tgl;
    logic        drv_tgl;

    pp_sel_decode #(.SEL_W(2)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_sel   (ratio_sel),
        .mode        (mode),
        .sel_changed (sel_changed)
    );

    pp_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .osc_tick    (osc_tick),
        .mode        (mode),
        .sel_changed (sel_changed),
        .state_q     (state_q),
        .step        (step),
        .first       (first),
        .clear       (clear)
    );

    pp_tick_div #(.FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .step     (step),
        .first    (first),
        .mode     (mode),
        .sync_tgl (sync_tgl),
        .drv_tgl  (drv_tgl)
    );

    pp_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .step     (step),
        .first    (first),
        .sync_tgl (sync_tgl),
        .drv_tgl  (drv_tgl),
        .drive_a  (drive_a),
        .drive_b  (drive_b),
        .sync_clk (sync_clk)
    );

    assert_complement_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (drive_a != drive_b));

    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> (!drive_a && !drive_b && !sync_clk));

    assert_edge_follows_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_RUN && drive_a != $past(drive_a))
        |-> (sync_clk != $past(sync_clk)));

    assert_lock_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!drive_a && !drive_b && !sync_clk));

    assert_sel_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_changed |=> (!drive_a && !drive_b && !sync_clk));

    assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && supply_ok && !sel_changed && mode != MODE_OFF)
        |=> ($stable(drive_a) && $stable(drive_b) && $stable(sync_clk)));

endmodule

// File: tb/sim_pp_phase_gen.sv
`timescale 1ns/1ps
module sim_pp_phase_gen;

    typedef struct packed {
        logic [1:0] sel;
        logic [5:0] n;
        logic [3:0] s;
        logic [3:0] a;
        logic [3:0] b;
    } vec_t;

    // sel, ticks, expected rises on sync_clk, drive_a, drive_b
    localparam vec_t VEC [8] = '{
        '{2'b01, 6'd16, 4'd4, 4'd4, 4'd4},
        '{2'b10, 6'd16, 4'd8, 4'd4, 4'd4},
        '{2'b11, 6'd16, 4'd8, 4'd2, 4'd2},
        '{2'b00, 6'd16, 4'd0, 4'd0, 4'd0},
        '{2'b01, 6'd6,  4'd2, 4'd2, 4'd1},
        '{2'b11, 6'd6,  4'd3, 4'd1, 4'd1},
        '{2'b10, 6'd5,  4'd3, 4'd2, 4'd1},
        '{2'b11, 6'd9,  4'd5, 4'd2, 4'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       supply_ok = 1'b1;
    logic [1:0] ratio_sel = 2'b00;
    logic       drive_a;
    logic       drive_b;
    logic       sync_clk;

    int n_chk = 0;
    int n_fail = 0;
    bit in_run = 1'b0;
    int rise_s = 0, rise_a = 0, rise_b = 0;
    int overlap = 0, lead = 0;
    logic pa = 1'b0, pb = 1'b0, ps = 1'b0;

    always #10 clk = ~clk;

    pp_phase_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_tick  (osc_tick),
        .supply_ok (supply_ok),
        .ratio_sel (ratio_sel),
        .drive_a   (drive_a),
        .drive_b   (drive_b),
        .sync_clk  (sync_clk)
    );

    always @(negedge clk) begin
        if (in_run) begin
            if (drive_a && !pa) rise_a++;
            if (drive_b && !pb) rise_b++;
            if (sync_clk && !ps) rise_s++;
            if (drive_a && drive_b) overlap++;
            if ((drive_a != pa || drive_b != pb) && sync_clk == ps) lead++;
        end
        pa = drive_a;
        pb = drive_b;
        ps = sync_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_out(input string req, input logic ea, input logic eb, input logic es);
        chk(drive_a == ea && drive_b == eb && sync_clk == es, req,
            {drive_a, drive_b, sync_clk}, {ea, eb, es});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Pulse one tick; returns after the resulting output update.
    task automatic tick1();
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R11: reset, with ticks arriving during reset
        ratio_sel = 2'b11;
        tick1();
        tick1();
        chk_out("R11 outputs low in reset", 1'b0, 1'b0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        idle(1);
        chk_out("R11 outputs low after reset", 1'b0, 1'b0, 1'b0);

        // Vector table: edge counts over a window of ticks per mode
        for (int v = 0; v < 8; v++) begin
            ratio_sel = 2'b00;
            idle(3);
            ratio_sel = VEC[v].sel;
            idle(2);
            rise_s = 0; rise_a = 0; rise_b = 0; overlap = 0; lead = 0;
            in_run = 1'b1;
            for (int t = 0; t < int'(VEC[v].n); t++) begin
                tick1();
                idle(2);
            end
            in_run = 1'b0;
            // R2 R3 R4 R5 depending on the select code
            chk(rise_s == int'(VEC[v].s), "R3/R4/R5/R2 sync rises", rise_s, int'(VEC[v].s));
            chk(rise_a == int'(VEC[v].a), "R3/R4/R5/R2 drive_a rises", rise_a, int'(VEC[v].a));
            chk(rise_b == int'(VEC[v].b), "R3/R4/R5/R2 drive_b rises", rise_b, int'(VEC[v].b));
            chk(overlap == 0, "R1 overlap", overlap, 0);
            chk(lead == 0, "R6 drive edge without sync edge", lead, 0);
        end

        // R8 R9: start at ratio 4, first pulse full width
        ratio_sel = 2'b00;
        idle(2);
        ratio_sel = 2'b11;
        idle(2);
        tick1();
        chk_out("R8 start phase", 1'b1, 1'b0, 1'b1);
        tick1();
        chk_out("R5 ratio4 tick1", 1'b1, 1'b0, 1'b0);
        tick1();
        chk_out("R9 ratio4 tick2", 1'b1, 1'b0, 1'b1);
        tick1();
        chk_out("R9 ratio4 tick3", 1'b1, 1'b0, 1'b0);
        tick1();
        chk_out("R9 ratio4 tick4 ends pulse", 1'b0, 1'b1, 1'b1);

        // R10: no ticks, no change
        idle(10);
        chk_out("R10 hold without ticks", 1'b0, 1'b1, 1'b1);

        // R7: lockout during run, ticks ignored, restart on return
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk);
        chk_out("R7 lockout forces low", 1'b0, 1'b0, 1'b0);
        tick1();
        tick1();
        chk_out("R7 ticks ignored in lockout", 1'b0, 1'b0, 1'b0);
        @(negedge clk) supply_ok = 1'b1;
        idle(2);
        chk_out("R7 armed low after return", 1'b0, 1'b0, 1'b0);
        tick1();
        chk_out("R7 restart on tick", 1'b1, 1'b0, 1'b1);

        // R8: select change in the same cycle as a tick
        @(negedge clk) begin ratio_sel = 2'b10; osc_tick = 1'b1; end
        @(negedge clk) osc_tick = 1'b0;
        chk_out("R8 change with tick goes low", 1'b0, 1'b0, 1'b0);
        tick1();
        chk_out("R8 restart after change", 1'b1, 1'b0, 1'b1);
        tick1();
        chk_out("R4 ratio2 tick1", 1'b1, 1'b0, 1'b0);
        tick1();
        chk_out("R4 ratio2 tick2", 1'b0, 1'b1, 1'b1);

        // R7: supply drop in the same cycle as a tick
        @(negedge clk) begin supply_ok = 1'b0; osc_tick = 1'b1; end
        @(negedge clk) osc_tick = 1'b0;
        chk_out("R7 drop with tick goes low", 1'b0, 1'b0, 1'b0);
        @(negedge clk) supply_ok = 1'b1;
        idle(1);
        tick1();
        chk_out("R7 restart after drop", 1'b1, 1'b0, 1'b1);

        // R2: disable while running, ticks have no effect
        @(negedge clk) ratio_sel = 2'b00;
        @(negedge clk);
        chk_out("R2 disable forces low", 1'b0, 1'b0, 1'b0);
        tick1();
        tick1();
        chk_out("R2 ticks ignored when off", 1'b0, 1'b0, 1'b0);

        // R3: ratio 1, sync tracks drive_a
        ratio_sel = 2'b01;
        idle(2);
        tick1();
        chk_out("R3 ratio1 start", 1'b1, 1'b0, 1'b1);
        tick1();
        chk_out("R3 ratio1 tick1 hold", 1'b1, 1'b0, 1'b1);
        tick1();
        chk_out("R3 ratio1 tick2", 1'b0, 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule